// File: doc/BRIEF.md
# SD Card Clock, Power and Bus-Width Control

This block derives the SD card clock from the system clock through a programmable divider. A 7-bit field `d` gives a card clock of sysclk/(2*(d+1)), so the fastest card clock is half the system clock and the slowest uses d = 127. With the card clock it drives one-cycle strobes that tell the command and data shifters where each card-clock edge falls. The clock can be stopped and restarted without glitches, and it always rests low.

The block also holds two more registers. The power register carries a 4-bit supply level and a power-on bit for the external regulator. The bus-width register chooses between 1-bit and 4-bit data lines and carries a read-only flag that reports whether 4-bit mode exists. Software reaches all three registers through a simple single-cycle write port and a combinational read port.

Top module: `sdclk_pwr_ctrl`

## Requirements
- R1: After reset, `sd_clk` is low, the clock is stopped, `card_pwr_en` is 0, `card_vlevel` is 0 and `bus_4bit` is 0. The registers then read back as follows: clock register 0x17F (stop bit set, divider 127), power register 0x000, bus register 0x009 (1-bit mode with the capability flag set).
- R2: While the clock runs with divider value d (clock register bits 6:0), every high phase and every low phase of `sd_clk` lasts exactly d+1 system-clock cycles.
- R3: A divider written while `sd_clk` is high does not alter that high phase. The new value applies from the following low phase onwards.
- R4: Setting the stop bit (clock register bit 8) ends the clock. If `sd_clk` is high, the high phase completes at full length; if it is low, the clock stops at once. In both cases `sd_clk` then stays low. When the stop bit is cleared, the clock restarts with a low phase of at least d+1 cycles.
- R5: `shift_rise` is high for exactly the one system-clock cycle in which `sd_clk` has just risen. `shift_fall` is high for exactly the one cycle in which `sd_clk` has just fallen. Neither strobe pulses at any other time.
- R6: The power register (address 1) holds the supply level in bits 3:0 and power-on in bit 4. These drive `card_vlevel` and `card_pwr_en` from the cycle after the write. Clearing bit 4 drops `card_pwr_en` and keeps the level.
- R7: In the bus register (address 2), writing bit 2 as 1 selects 4-bit mode (`bus_4bit` = 1) and writing it as 0 selects 1-bit mode. A read returns bit 0 = 1-bit active, bit 2 = 4-bit active and bit 3 = capability flag. Bit 3 is read-only and a write to it has no effect.
- R8: The high-speed bit (clock register bit 9) and the SD-mode bit (clock register bit 7) are stored, read back, and drive `hs_mode` and `sd_mode`.
- R9: Address 3 reads as zero, and writing to it changes no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 clock, 1 power, 2 bus width |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| sd_clk | output | 1 | Card clock |
| shift_rise | output | 1 | One-cycle strobe after each rising edge of the card clock |
| shift_fall | output | 1 | One-cycle strobe after each falling edge of the card clock |
| card_pwr_en | output | 1 | Card power enable |
| card_vlevel | output | 4 | Supply level code |
| bus_4bit | output | 1 | 4-bit data bus selected |
| hs_mode | output | 1 | High-speed timing selected |
| sd_mode | output | 1 | SD-mode bit |

## Verification
The divider is run with three kinds of setting: d = 2, the d = 0 limit and a mid value of 5. Each run checks every phase width against d+1; the d = 0 run shows whether the phase counter compares one cycle off. In a second pattern the divider changes from 3 to 1 during a high phase, which shows whether a new value can cut into a running phase. Stops are issued in both the high and the low phase, and restarts follow them, to tell apart a clean stop from a clipped pulse or a stray extra edge. The register patterns toggle each power, bus and mode bit on its own and then write the read-only flag and the unmapped address, to tell a stored bit apart from one that is ignored.

// File: rtl/sdcp_pkg.sv
package sdcp_pkg;

  // register addresses
  localparam logic [1:0] ADR_CLK  = 2'd0;
  localparam logic [1:0] ADR_PWR  = 2'd1;
  localparam logic [1:0] ADR_BUS  = 2'd2;
  localparam logic [1:0] ADR_NONE = 2'd3;

  // bus-width register bit positions
  localparam int BUS_NARROW_BIT = 0;
  localparam int BUS_WIDE_BIT   = 2;
  localparam int BUS_CAP_BIT    = 3;

  // number of system-clock cycles in one card-clock phase
  function automatic int unsigned phase_cycles(input int unsigned div);
    return div + 1;
  endfunction

endpackage

// File: rtl/sdcp_regs.sv
module sdcp_regs #(
  parameter int DIV_W   = 7,
  parameter int LVL_W   = 4,
  parameter int DATA_W  = 16,
  parameter bit WIDE_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]  div_o,
  output logic              stop_o,
  output logic              sdm_o,
  output logic              hs_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              pon_o,
  output logic              wide_o
);
  import sdcp_pkg::*;

  localparam int SDM_BIT = DIV_W;
  localparam int OFF_BIT = DIV_W + 1;
  localparam int HS_BIT  = DIV_W + 2;
  localparam int PON_BIT = LVL_W;

  logic wr_clk, wr_pwr, wr_bus;
  assign wr_clk = we && (addr == ADR_CLK);
  assign wr_pwr = we && (addr == ADR_PWR);
  assign wr_bus = we && (addr == ADR_BUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_o  <= '1;
      stop_o <= 1'b1;
      sdm_o  <= 1'b0;
      hs_o   <= 1'b0;
    end else if (wr_clk) begin
      div_o  <= wdata[DIV_W-1:0];
      sdm_o  <= wdata[SDM_BIT];
      stop_o <= wdata[OFF_BIT];
      hs_o   <= wdata[HS_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o <= '0;
      pon_o <= 1'b0;
    end else if (wr_pwr) begin
      lvl_o <= wdata[LVL_W-1:0];
      pon_o <= wdata[PON_BIT];
    end
  end

  generate
    if (WIDE_OK) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wide_o <= 1'b0;
        else if (wr_bus) wide_o <= wdata[BUS_WIDE_BIT];
      end
    end else begin : g_narrow
      assign wide_o = 1'b0;
    end
  endgenerate

  generate
    if (DATA_W > HS_BIT + 1) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:HS_BIT+1];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CLK: begin
        rdata[DIV_W-1:0] = div_o;
        rdata[SDM_BIT]   = sdm_o;
        rdata[OFF_BIT]   = stop_o;
        rdata[HS_BIT]    = hs_o;
      end
      ADR_PWR: begin
        rdata[LVL_W-1:0] = lvl_o;
        rdata[PON_BIT]   = pon_o;
      end
      ADR_BUS: begin
        rdata[BUS_NARROW_BIT] = !wide_o;
        rdata[BUS_WIDE_BIT]   = wide_o;
        rdata[BUS_CAP_BIT]    = WIDE_OK;
      end
      default: rdata = '0;
    endcase
  end

  // R6: the power outputs follow the written word one cycle later
  assert_pwr_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pwr |=> (pon_o == $past(wdata[PON_BIT])) && (lvl_o == $past(wdata[LVL_W-1:0])));

  // R7: the width follows bit 2 of the write, gated by the capability
  assert_bus_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bus |=> wide_o == ($past(wdata[BUS_WIDE_BIT]) && WIDE_OK));

  // R8: the mode bits are stored
  assert_mode_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clk |=> (hs_o == $past(wdata[HS_BIT])) && (sdm_o == $past(wdata[SDM_BIT])));

  // R9: a write to the unmapped address leaves every register as it was
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADR_NONE) |=> $stable({div_o, stop_o, sdm_o, hs_o, lvl_o, pon_o, wide_o}));

endmodule

// File: rtl/sdcp_clkgen.sv
module sdcp_clkgen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_req,
  input  logic             stop_req,
  output logic             sd_clk,
  output logic             rise_stb,
  output logic             fall_stb
);
  import sdcp_pkg::*;

  logic             run_q;
  logic             clk_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;

  // events brought out for the assertions
  logic half_done, rise_evt, fall_evt, halt_evt;
  assign half_done = (cnt_q == div_q);
  assign rise_evt  = run_q && !clk_q && !stop_req && half_done;
  assign fall_evt  = run_q && clk_q && half_done;
  assign halt_evt  = run_q && !clk_q && stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      clk_q    <= 1'b0;
      cnt_q    <= '0;
      div_q    <= '1;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= rise_evt;
      fall_stb <= fall_evt;
      if (!run_q) begin
        clk_q <= 1'b0;
        cnt_q <= '0;
        div_q <= div_req;
        if (!stop_req) run_q <= 1'b1;
      end else if (!clk_q) begin
        if (halt_evt) begin
          run_q <= 1'b0;
          cnt_q <= '0;
        end else if (rise_evt) begin
          clk_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (fall_evt) begin
          clk_q <= 1'b0;
          cnt_q <= '0;
          div_q <= div_req;
          run_q <= !stop_req;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sd_clk = clk_q;

  // checker counter: length of the current high phase
  logic [DIV_W:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_len <= '0;
    else if (clk_q) hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  // R2: every completed high phase lasts div+1 cycles
  assert_hi_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_q) |-> 32'(hi_len) == phase_cycles(32'($past(div_q))));

  // R3: the divider in use changes only at a falling edge or while idle
  assert_div_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> ($past(!run_q) || $fell(clk_q)));

  // R4: an idle generator keeps the clock low, and a stop in the low phase halts it
  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !clk_q);
  assert_halt_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> !run_q && !clk_q);

  // R5: strobes mark real edges and never coincide
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));
  assert_rise_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $rose(clk_q));
  assert_fall_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> $fell(clk_q));

endmodule

// File: rtl/sdclk_pwr_ctrl.sv
module sdclk_pwr_ctrl #(
  parameter int DIV_W   = 7,
  parameter int LVL_W   = 4,
  parameter int DATA_W  = 16,
  parameter bit WIDE_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sd_clk,
  output logic              shift_rise,
  output logic              shift_fall,
  output logic              card_pwr_en,
  output logic [LVL_W-1:0]  card_vlevel,
  output logic              bus_4bit,
  output logic              hs_mode,
  output logic              sd_mode
);

  logic [DIV_W-1:0] div_w;
  logic             stop_w;

  sdcp_regs #(
    .DIV_W  (DIV_W),
    .LVL_W  (LVL_W),
    .DATA_W (DATA_W),
    .WIDE_OK(WIDE_OK)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .div_o (div_w),
    .stop_o(stop_w),
    .sdm_o (sd_mode),
    .hs_o  (hs_mode),
    .lvl_o (card_vlevel),
    .pon_o (card_pwr_en),
    .wide_o(bus_4bit)
  );

  sdcp_clkgen #(
    .DIV_W(DIV_W)
  ) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_req (div_w),
    .stop_req(stop_w),
    .sd_clk  (sd_clk),
    .rise_stb(shift_rise),
    .fall_stb(shift_fall)
  );

endmodule

// File: tb/sdclk_pwr_ctrl_bench.sv
module sdclk_pwr_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        sd_clk, shift_rise, shift_fall;
  logic        card_pwr_en, bus_4bit, hs_mode, sd_mode;
  logic [3:0]  card_vlevel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // scoreboard queues: expected high and low phase widths
  int q_hi[$];
  int q_lo[$];
  bit skip_lo = 1'b1;

  always #5 clk = ~clk;

  sdclk_pwr_ctrl u_sdclk_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_clk(sd_clk),
    .shift_rise(shift_rise), .shift_fall(shift_fall),
    .card_pwr_en(card_pwr_en), .card_vlevel(card_vlevel),
    .bus_4bit(bus_4bit), .hs_mode(hs_mode), .sd_mode(sd_mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a falling clock edge; returns at the next one with the write done
  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wait_rises(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (shift_rise) seen++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_run(input int n_hi, input int w_hi, input int n_lo, input int w_lo);
    for (int i = 0; i < n_hi; i++) q_hi.push_back(w_hi);
    for (int i = 0; i < n_lo; i++) q_lo.push_back(w_lo);
  endtask

  // start the clock with divider d and measure the first low phase (R4)
  task automatic start_clk(input int d);
    int lo = 0;
    skip_lo = 1'b1;
    reg_write(2'd0, 16'(d));
    while (!sd_clk) begin
      @(negedge clk);
      lo++;
    end
    checks++;
    if (lo < d + 1 || lo > d + 3) begin
      failures++;
      $display("FAIL R4 restart low phase actual=%0d expected=%0d..%0d", lo, d + 1, d + 3);
    end
  endtask

  task automatic drained(input string tag);
    chk(tag, "pending high phases", q_hi.size(), 0);
    chk(tag, "pending low phases", q_lo.size(), 0);
    chk(tag, "clock rests low", int'(sd_clk), 0);
  endtask

  // monitor: strobes and phase widths against the scoreboard
  initial begin : monitor
    logic prev = 1'b0;
    int hi_cnt = 0;
    int lo_cnt = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        automatic bit r = sd_clk && !prev;
        automatic bit f = !sd_clk && prev;
        if (shift_rise != r || shift_fall != f) begin
          checks++; failures++;
          $display("FAIL R5 strobes actual=%0d%0d expected=%0d%0d",
                   shift_rise, shift_fall, r, f);
        end
        if (r) begin
          checks++;
          if (!skip_lo) begin
            if (q_lo.size() == 0) begin
              failures++;
              $display("FAIL R2 unexpected low phase actual=%0d expected=none", lo_cnt);
            end else begin
              automatic int e = q_lo.pop_front();
              if (lo_cnt != e) begin
                failures++;
                $display("FAIL R2 low width actual=%0d expected=%0d", lo_cnt, e);
              end
            end
          end
          skip_lo = 1'b0;
          lo_cnt = 0;
        end
        if (f) begin
          checks++;
          if (q_hi.size() == 0) begin
            failures++;
            $display("FAIL R4 unexpected pulse actual=%0d expected=none", hi_cnt);
          end else begin
            automatic int e = q_hi.pop_front();
            if (hi_cnt != e) begin
              failures++;
              $display("FAIL R2 high width actual=%0d expected=%0d", hi_cnt, e);
            end
          end
          hi_cnt = 0;
          lo_cnt = 0;
        end
        if (sd_clk) hi_cnt++;
        else        lo_cnt++;
        prev = sd_clk;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    int v;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    chk("R1", "sd_clk", int'(sd_clk), 0);
    chk("R1", "card_pwr_en", int'(card_pwr_en), 0);
    chk("R1", "card_vlevel", int'(card_vlevel), 0);
    chk("R1", "bus_4bit", int'(bus_4bit), 0);
    reg_read(2'd0, v); chk("R1", "clock reg", v, 'h17F);
    reg_read(2'd1, v); chk("R1", "power reg", v, 'h000);
    reg_read(2'd2, v); chk("R1", "bus reg", v, 'h009);
    idle(20);
    chk("R1", "no clock after reset", int'(sd_clk), 0);

    // R2: steady run, divider 2
    push_run(4, 3, 3, 3);
    start_clk(2);
    wait_rises(3);
    reg_write(2'd0, 16'h0102);   // R4: stop during a high phase
    idle(30);
    drained("R4");

    // R3: divider change from 3 to 1 during a high phase
    push_run(2, 4, 1, 4);
    start_clk(3);
    wait_rises(1);
    reg_write(2'd0, 16'h0001);
    push_run(3, 2, 3, 2);
    wait_rises(3);
    reg_write(2'd0, 16'h0101);
    idle(30);
    drained("R3");

    // R2: fastest setting, divider 0
    push_run(5, 1, 4, 1);
    start_clk(0);
    wait_rises(4);
    reg_write(2'd0, 16'h0100);
    idle(20);
    drained("R2");

    // R4: stop issued during a low phase, divider 5
    push_run(1, 6, 0, 0);
    start_clk(5);
    while (sd_clk) @(negedge clk);
    @(negedge clk);
    reg_write(2'd0, 16'h0105);
    idle(40);
    drained("R4");

    // R6: power register
    reg_write(2'd1, 16'h001A);
    chk("R6", "pwr_en on", int'(card_pwr_en), 1);
    chk("R6", "level", int'(card_vlevel), 'hA);
    reg_read(2'd1, v); chk("R6", "power readback", v, 'h01A);
    reg_write(2'd1, 16'h000A);
    chk("R6", "pwr_en off", int'(card_pwr_en), 0);
    chk("R6", "level kept", int'(card_vlevel), 'hA);

    // R7: bus width and read-only capability flag
    reg_write(2'd2, 16'h0004);
    chk("R7", "4-bit selected", int'(bus_4bit), 1);
    reg_read(2'd2, v); chk("R7", "bus readback wide", v, 'h00C);
    reg_write(2'd2, 16'h0001);
    chk("R7", "1-bit selected", int'(bus_4bit), 0);
    reg_write(2'd2, 16'h0008);
    chk("R7", "flag write ignored", int'(bus_4bit), 0);
    reg_read(2'd2, v); chk("R7", "bus readback narrow", v, 'h009);

    // R8: high-speed and SD-mode bits, clock kept stopped
    reg_write(2'd0, 16'h0385);
    chk("R8", "hs_mode", int'(hs_mode), 1);
    chk("R8", "sd_mode", int'(sd_mode), 1);
    reg_read(2'd0, v); chk("R8", "clock readback", v, 'h385);
    idle(20);
    chk("R8", "stopped clock", int'(sd_clk), 0);

    // R9: unmapped address
    reg_write(2'd3, 16'hFFFF);
    reg_read(2'd3, v); chk("R9", "unmapped reads zero", v, 0);
    reg_read(2'd1, v); chk("R9", "power unchanged", v, 'h00A);
    reg_read(2'd2, v); chk("R9", "bus unchanged", v, 'h009);
    reg_read(2'd0, v); chk("R9", "clock unchanged", v, 'h385);
    chk("R9", "pwr_en unchanged", int'(card_pwr_en), 0);
    idle(10);
    drained("R9");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule